// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs once, between the release of reset and the first instruction fetch of a small processor core. It picks the vector table the core boots from: the user flash table, whose base comes from a vector-table offset value, or a fixed table in on-chip ROM. It then reads the initial main stack pointer and the reset handler address over a simple 32-bit read port. The read port has a request, an address, a ready and a read-data signal.

The flash table is refused, and the ROM table used instead, in two cases. The first is when the boot enable input is low at reset release. The second is when the flash word at byte address 0x00000004 reads as erased (all ones). The fetched stack pointer and handler address are aligned by clearing their low bits. They are presented to the core together with a fixed link-register value and a one-cycle start-fetch strobe. After that strobe the block stays idle until the next reset. All other core registers are reset by their own logic.

Top module: `boot_vector_seq`

## Requirements
- R1: While rst_n is low, msp_o and pc_o are 0, start_fetch_o is 0, and lr_o is 0xFFFFFFFF.
- R2: When boot enable was high at reset release, the first read issued is the probe read of byte address 0x00000004.
- R3: When boot enable was high and the probe word is not 0xFFFFFFFF, the table base is {vtor[31:7], 7'b0}. The stack pointer is read from the base and the handler from base+4.
- R4: When the probe word is 0xFFFFFFFF, the table base is 0x01000000: stack pointer from 0x01000000, handler from 0x01000004.
- R5: When boot enable was low at reset release, no probe read is made. The only reads are 0x01000000 and then 0x01000004.
- R6: msp_o takes the word returned by the stack pointer read with bits [1:0] cleared.
- R7: pc_o takes the word returned by the handler read with bit 0 cleared.
- R8: A read keeps mem_req_o high and mem_addr_o unchanged until a cycle with mem_ready_i high. mem_rdata_i is used only in that cycle.
- R9: The stack pointer read completes before the handler read is issued. Exactly three reads occur with the probe, and two without it.
- R10: start_fetch_o is high for exactly one cycle, the cycle after the handler read completes, when msp_o and pc_o already hold their final values. After it, no further reads are issued, the strobe stays low, and msp_o and pc_o do not change.
- R11: boot_en_i and vtor_i are taken as they stand in the last cycle of reset. Changes after reset release have no effect on the addresses read.
- R12: lr_o is 0xFFFFFFFF and bits [1:0] of psp_o are 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_en_i | input | 1 | Boot configuration enable; low forces the ROM table |
| vtor_i | input | 32 | Vector table offset; bits [31:7] give the flash table base |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_ready_i | input | 1 | Read completes in this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| msp_o | output | 32 | Initial main stack pointer |
| psp_o | output | 32 | Process stack pointer preset, low two bits zero |
| lr_o | output | 32 | Link register preset |
| pc_o | output | 32 | Reset handler address for the first fetch |
| start_fetch_o | output | 1 | One-cycle strobe: vectors loaded, fetch may begin |

## Verification
The bench targets four corner cases:

- **Flash base 0.** The handler read hits the same address as the probe. A design that cached the probe or skipped the read would hand the core the wrong handler.
- **Probe word one bit short of erased.** It must keep the flash table. A loose erased test would fall back to ROM.
- **Boot enable low.** A design that probed anyway would show an extra read.
- **Configuration changing right after reset release.** A design that sampled it late would switch tables mid-sequence.

Random wait states on every read catch capture of read data before ready, and addresses that drift while a read is held. Stack and handler words with their low bits set catch missing or wrong alignment masks.

// File: rtl/bvs_pkg.sv
// Shared types for the reset vector fetch sequencer.
package bvs_pkg;

    // Sequencer states; ST_DONE is terminal until the next reset.
    typedef enum logic [1:0] {
        ST_PROBE    = 2'd0,
        ST_FETCH_SP = 2'd1,
        ST_FETCH_PC = 2'd2,
        ST_DONE     = 2'd3
    } bvs_state_e;

    // Builds a mask that clears the lowest 'lsbs' bits of a word.
    function automatic logic [31:0] low_clear_mask(input int lsbs);
        logic [31:0] m;
        m = '1;
        for (int i = 0; i < lsbs; i++) begin
            m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/bvs_cfg_latch.sv
// Boot configuration capture.
// Holds the boot enable and the table offset as they stand while reset is
// asserted, so the last reset cycle fixes them for the whole sequence.
// Assumes rst_n is synchronous to clk. The low BASE_LSB offset bits are
// dropped, since the table base is aligned to 2**BASE_LSB bytes.
module bvs_cfg_latch #(
    parameter int ADDR_W   = 32,
    parameter int BASE_LSB = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en_i,
    input  logic [ADDR_W-1:0] vtor_i,
    output logic              boot_en_o,
    output logic [ADDR_W-1:0] flash_base_o
);

    localparam int HI_W = ADDR_W - BASE_LSB;

    logic            en_q;
    logic [HI_W-1:0] base_hi_q;
    logic            unused_vtor_low;

    // Track the configuration inputs during reset; freeze them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= boot_en_i;
            base_hi_q <= vtor_i[ADDR_W-1:BASE_LSB];
        end
    end

    assign unused_vtor_low = ^vtor_i[BASE_LSB-1:0];
    assign boot_en_o       = en_q;
    assign flash_base_o    = {base_hi_q, {BASE_LSB{1'b0}}};

endmodule

// File: rtl/bvs_fsm.sv
// Vector fetch state machine.
// Decides between the flash and ROM tables, then issues the stack pointer
// read and the handler read in that order. Each read holds its request and
// address until mem_ready_i is seen. Request and address are decoded from
// the state, so the read port adds no cycle of its own.
module bvs_fsm
    import bvs_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              DATA_W     = 32,
    parameter int              WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] PROBE_ADDR = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en_i,
    input  logic [ADDR_W-1:0] flash_base_i,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              sp_cap_o,
    output logic              pc_cap_o,
    output bvs_state_e        state_o
);

    localparam logic [DATA_W-1:0] ERASED_WORD = '1;
    localparam logic [ADDR_W-1:0] STEP        = ADDR_W'(WORD_BYTES);

    bvs_state_e        state_q;
    bvs_state_e        state_d;
    logic              rom_sel_q;
    logic [ADDR_W-1:0] table_base;

    // Next-state decode: advance only when the current read completes.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PROBE:    if (!boot_en_i || mem_ready_i) state_d = ST_FETCH_SP;
            ST_FETCH_SP: if (mem_ready_i) state_d = ST_FETCH_PC;
            ST_FETCH_PC: if (mem_ready_i) state_d = ST_DONE;
            default:     state_d = ST_DONE;
        endcase
    end

    // State register, restarting at the probe step on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PROBE;
        else        state_q <= state_d;
    end

    // Table choice: ROM when boot is disabled or the probed word is erased.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_sel_q <= 1'b0;
        end else if (state_q == ST_PROBE) begin
            if (!boot_en_i)       rom_sel_q <= 1'b1;
            else if (mem_ready_i) rom_sel_q <= (mem_rdata_i == ERASED_WORD);
        end
    end

    assign table_base = rom_sel_q ? ROM_BASE : flash_base_i;

    // Read port decode from the current state.
    always_comb begin
        mem_req_o  = 1'b0;
        mem_addr_o = '0;
        unique case (state_q)
            ST_PROBE: begin
                mem_req_o  = boot_en_i;
                mem_addr_o = PROBE_ADDR;
            end
            ST_FETCH_SP: begin
                mem_req_o  = 1'b1;
                mem_addr_o = table_base;
            end
            ST_FETCH_PC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = table_base + STEP;
            end
            default: begin
                mem_req_o  = 1'b0;
                mem_addr_o = '0;
            end
        endcase
    end

    assign sp_cap_o = (state_q == ST_FETCH_SP) && mem_ready_i;
    assign pc_cap_o = (state_q == ST_FETCH_PC) && mem_ready_i;
    assign state_o  = state_q;

endmodule

// File: rtl/bvs_vec_regs.sv
// Vector holding registers.
// Captures the aligned stack pointer and handler address when the state
// machine flags a completed read. Raises the start strobe one cycle after
// the handler capture, when both values are already visible. The link
// register and process stack presets are fixed values.
module bvs_vec_regs
    import bvs_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SP_ALIGN = 2,
    parameter int PC_ALIGN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_cap_i,
    input  logic              pc_cap_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] msp_o,
    output logic [DATA_W-1:0] psp_o,
    output logic [DATA_W-1:0] lr_o,
    output logic [DATA_W-1:0] pc_o,
    output logic              start_o
);

    localparam logic [DATA_W-1:0] SP_MASK   = DATA_W'(low_clear_mask(SP_ALIGN));
    localparam logic [DATA_W-1:0] PC_MASK   = DATA_W'(low_clear_mask(PC_ALIGN));
    localparam logic [DATA_W-1:0] LR_PRESET = '1;

    logic [DATA_W-1:0] msp_q;
    logic [DATA_W-1:0] pc_q;
    logic              start_q;

    // Stack pointer capture with its alignment bits cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)        msp_q <= '0;
        else if (sp_cap_i) msp_q <= rdata_i & SP_MASK;
    end

    // Handler address capture with the state bit cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (pc_cap_i) pc_q <= rdata_i & PC_MASK;
    end

    // One-cycle start strobe following the handler capture.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= pc_cap_i;
    end

    assign msp_o   = msp_q;
    assign pc_o    = pc_q;
    assign start_o = start_q;
    assign lr_o    = LR_PRESET;
    assign psp_o   = '0;

endmodule

// File: rtl/boot_vector_seq.sv
// Reset vector fetch sequencer, top level.
// Runs once after reset release: chooses the boot table, fetches the
// initial stack pointer and the handler address, then strobes the core to
// begin fetching. Assumes a read port that answers each request with one
// ready pulse, and a synchronous active-low reset.
module boot_vector_seq
    import bvs_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                BASE_LSB   = 7,
    parameter int                WORD_BYTES = 4,
    parameter int                SP_ALIGN   = 2,
    parameter int                PC_ALIGN   = 1,
    parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0100_0000,
    parameter logic [ADDR_W-1:0] PROBE_ADDR = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en_i,
    input  logic [ADDR_W-1:0] vtor_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] msp_o,
    output logic [DATA_W-1:0] psp_o,
    output logic [DATA_W-1:0] lr_o,
    output logic [DATA_W-1:0] pc_o,
    output logic              start_fetch_o
);

    logic              cfg_en;
    logic [ADDR_W-1:0] flash_base;
    logic              sp_cap;
    logic              pc_cap;
    bvs_state_e        fsm_state;

    bvs_cfg_latch #(
        .ADDR_W   (ADDR_W),
        .BASE_LSB (BASE_LSB)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_en_i    (boot_en_i),
        .vtor_i       (vtor_i),
        .boot_en_o    (cfg_en),
        .flash_base_o (flash_base)
    );

    bvs_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .WORD_BYTES (WORD_BYTES),
        .ROM_BASE   (ROM_BASE),
        .PROBE_ADDR (PROBE_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_en_i    (cfg_en),
        .flash_base_i (flash_base),
        .mem_ready_i  (mem_ready_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .sp_cap_o     (sp_cap),
        .pc_cap_o     (pc_cap),
        .state_o      (fsm_state)
    );

    bvs_vec_regs #(
        .DATA_W   (DATA_W),
        .SP_ALIGN (SP_ALIGN),
        .PC_ALIGN (PC_ALIGN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sp_cap_i (sp_cap),
        .pc_cap_i (pc_cap),
        .rdata_i  (mem_rdata_i),
        .msp_o    (msp_o),
        .psp_o    (psp_o),
        .lr_o     (lr_o),
        .pc_o     (pc_o),
        .start_o  (start_fetch_o)
    );

endmodule

// File: rtl/bvs_checker.sv
// Protocol and capture checks for boot_vector_seq, attached by bind.
// Observes the read port, the outputs and the state machine state.
module bvs_checker
    import bvs_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SP_ALIGN = 2,
    parameter int PC_ALIGN = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ready_i,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic [DATA_W-1:0] msp_o,
    input logic [DATA_W-1:0] pc_o,
    input logic              start_fetch_o,
    input bvs_state_e        state
);

    localparam logic [DATA_W-1:0] SP_MASK = DATA_W'(low_clear_mask(SP_ALIGN));
    localparam logic [DATA_W-1:0] PC_MASK = DATA_W'(low_clear_mask(PC_ALIGN));

    // R8: a read that is not yet answered keeps its request and address.
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R6: the stack pointer takes the answered word, aligned.
    p_sp_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_SP && mem_ready_i) |=> (msp_o == ($past(mem_rdata_i) & SP_MASK)));

    // R7: the handler address takes the answered word, aligned, with the strobe.
    p_pc_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_PC && mem_ready_i) |=> ((pc_o == ($past(mem_rdata_i) & PC_MASK)) && start_fetch_o));

    // R9: the handler read follows the completed stack pointer read.
    p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_SP && mem_ready_i) |=> (state == ST_FETCH_PC && mem_req_o));

    // R10: the strobe lasts one cycle and no read follows it.
    p_start_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_fetch_o |=> (!start_fetch_o && !mem_req_o));

    // R10: once finished, the loaded values stay put.
    p_final_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_DONE && $stable(msp_o) && $stable(pc_o)));

endmodule

bind boot_vector_seq bvs_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SP_ALIGN (SP_ALIGN),
    .PC_ALIGN (PC_ALIGN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ready_i   (mem_ready_i),
    .mem_rdata_i   (mem_rdata_i),
    .msp_o         (msp_o),
    .pc_o          (pc_o),
    .start_fetch_o (start_fetch_o),
    .state         (fsm_state)
);

// File: tb/sim_boot_vector_seq.sv
`timescale 1ns/1ps
// Self-checking bench: a memory model with random wait states answers the
// sequencer; expected addresses and values come from bench functions.
module sim_boot_vector_seq;

    localparam logic [31:0] ROM_BASE = 32'h0100_0000;
    localparam logic [31:0] PROBE    = 32'h0000_0004;
    localparam logic [31:0] ERASED   = 32'hFFFF_FFFF;

    logic        clk;
    logic        rst_n;
    logic        boot_en;
    logic [31:0] vtor_in;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic [31:0] msp;
    logic [31:0] psp;
    logic [31:0] lr;
    logic [31:0] pc;
    logic        start_fetch;

    int checks = 0;
    int errors = 0;

    logic [31:0] probe_word;
    logic [31:0] sp_word;
    logic [31:0] pc_word;
    logic [31:0] exp_sp_addr;
    logic [31:0] exp_pc_addr;

    boot_vector_seq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .boot_en_i     (boot_en),
        .vtor_i        (vtor_in),
        .mem_req_o     (mem_req),
        .mem_addr_o    (mem_addr),
        .mem_ready_i   (mem_ready),
        .mem_rdata_i   (mem_rdata),
        .msp_o         (msp),
        .psp_o         (psp),
        .lr_o          (lr),
        .pc_o          (pc),
        .start_fetch_o (start_fetch)
    );

    // 50 MHz clock.
    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    // Memory contents seen by the sequencer in the current trial.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a == PROBE)       return probe_word;
        if (a == exp_sp_addr) return sp_word;
        if (a == exp_pc_addr) return pc_word;
        return 32'hDEAD_BEEF;
    endfunction

    // Table base the requirements call for.
    function automatic logic [31:0] table_base(input logic en, input logic [31:0] vt,
                                               input logic [31:0] pw);
        if (!en || pw == ERASED) return ROM_BASE;
        return {vt[31:7], 7'b0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One complete boot: reset, sequence with random waits, final checks.
    task automatic run_trial(input logic en, input logic [31:0] vt,
                             input logic [31:0] pw, input logic [31:0] sw,
                             input logic [31:0] hw);
        logic [31:0] addrs [3];
        logic [31:0] cur_addr;
        logic [31:0] msp_done;
        logic [31:0] pc_done;
        int          ntx;
        int          waits;
        bit          in_txn;
        bit          got_done;
        string       tag;

        probe_word  = pw;
        sp_word     = sw;
        pc_word     = hw;
        exp_sp_addr = table_base(en, vt, pw);
        exp_pc_addr = exp_sp_addr + 32'd4;
        tag = !en ? "R5" : ((pw == ERASED) ? "R4" : "R3");
        for (int i = 0; i < 3; i++) addrs[i] = '0;
        cur_addr = '0;
        waits    = 0;

        @(negedge clk);
        rst_n     = 1'b0;
        boot_en   = en;
        vtor_in   = vt;
        mem_ready = 1'b0;
        mem_rdata = '0;
        repeat (2) @(negedge clk);
        check(msp == 0 && pc == 0 && !start_fetch && lr == ERASED, "R1",
              msp | pc, 32'h0);
        rst_n = 1'b1;

        ntx = 0; in_txn = 0; got_done = 0;
        for (int cyc = 0; cyc < 40 && !got_done; cyc++) begin
            @(negedge clk);
            if (cyc == 0) begin
                // R11: disturb the configuration right after release.
                boot_en = ~en;
                vtor_in = $urandom;
            end
            if (mem_ready) in_txn = 0;
            mem_ready = 1'b0;
            if (start_fetch) begin
                got_done = 1;
            end else if (mem_req) begin
                if (!in_txn) begin
                    in_txn   = 1;
                    if (ntx < 3) addrs[ntx] = mem_addr;
                    ntx++;
                    cur_addr = mem_addr;
                    waits    = $urandom_range(0, 3);
                end else begin
                    check(mem_addr == cur_addr, "R8", mem_addr, cur_addr);
                end
                if (waits == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                end else begin
                    waits--;
                    mem_rdata = $urandom;
                end
            end else if (in_txn) begin
                check(0, "R8", 32'h0, 32'h1);
            end
        end

        check(got_done, "R10", 32'(got_done), 32'h1);
        if (en) begin
            check(ntx == 3, "R9", ntx, 3);
            check(addrs[0] == PROBE, "R2", addrs[0], PROBE);
            check(addrs[1] == exp_sp_addr, tag, addrs[1], exp_sp_addr);
            check(addrs[2] == exp_pc_addr, "R9", addrs[2], exp_pc_addr);
        end else begin
            check(ntx == 2, "R5", ntx, 2);
            check(addrs[0] == exp_sp_addr, "R5", addrs[0], exp_sp_addr);
            check(addrs[1] == exp_pc_addr, "R9", addrs[1], exp_pc_addr);
        end
        check(msp == (mem_word(exp_sp_addr) & 32'hFFFF_FFFC), "R6",
              msp, mem_word(exp_sp_addr) & 32'hFFFF_FFFC);
        check(pc == (mem_word(exp_pc_addr) & 32'hFFFF_FFFE), "R7",
              pc, mem_word(exp_pc_addr) & 32'hFFFF_FFFE);
        check(lr == ERASED && psp[1:0] == 2'b00, "R12", lr, ERASED);
        msp_done = msp;
        pc_done  = pc;

        mem_ready = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!start_fetch && !mem_req && msp == msp_done && pc == pc_done,
                  "R10", pc, pc_done);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10: watchdog expired, got %0d cycles expected fewer", 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n     = 1'b0;
        boot_en   = 1'b1;
        vtor_in   = '0;
        mem_ready = 1'b0;
        mem_rdata = '0;

        // Directed corners.
        run_trial(1'b1, 32'h0000_0000, 32'h0000_1235, 32'h2000_4003, 32'h0);     // R3: base 0, handler is probe word
        run_trial(1'b1, 32'h0000_0000, ERASED, 32'h2000_0FFF, 32'h0100_0201);    // R4: erased flash
        run_trial(1'b0, 32'h0008_0000, 32'h0000_0101, 32'h2000_8001, 32'h0100_0401); // R5: boot disabled
        run_trial(1'b1, 32'h0004_00FF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R3: offset low bits masked, near-erased probe
        run_trial(1'b0, 32'h0000_0000, ERASED, 32'h0000_0003, 32'h0000_0001);    // R5 with erased flash

        // Random mix.
        for (int t = 0; t < 40; t++) begin
            logic        en;
            logic [31:0] pw;
            en = ($urandom_range(0, 3) != 0);
            pw = ($urandom_range(0, 2) == 0) ? ERASED : $urandom;
            run_trial(en, $urandom, pw, $urandom, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule